// File: doc/BRIEF.md
# Split-Transaction Bus Slot Sequencer

This block sits in one slot of a shared split-transaction bus. The address bus and the data bus are granted separately. Every slot runs the same five-cycle phase in lockstep: arbitration, resolution, address, decode, acknowledge. During arbitration each slot puts its requests on a shared set of wired-OR lines. Every slot captures the same snapshot of those lines and computes the same address and data winners from it. No central arbiter is needed.

When this slot wins the address bus, it drives address and command in the address cycle. When it wins the data bus, it drives the response tag in the address cycle. It then sends a block as four beats that start at acknowledge and run into the next phase. During acknowledge it drives its block-present feedback bit and captures the full feedback vector for the coherence logic outside the block. When nothing is requested and no beats are in flight, the sequencer alternates between arbitration and a single idle cycle.

Top module: `slot_bus_seq`

## Requirements
- R1: After reset the phase output is arbitration (code 0). The phase codes run resolution 1, address 2, decode 3, acknowledge 4, idle 5. A non-idle phase always steps 0, 1, 2, 3, 4 and then returns to 0.
- R2: An arbitration cycle in which the shared lines are all zero and no data beat is pending goes to idle (5). Idle always returns to arbitration. An arbitration cycle in which any line is set, or a beat is pending, goes to resolution.
- R3: In arbitration the slot enables exactly three line bits and drives them: bit SLOT_ID carries want_data, bit NSLOT+SLOT_ID carries want_addr, and bit 2*NSLOT+SLOT_ID carries want_urgent.
- R4: The line vector seen in the arbitration cycle is held as the snapshot. In resolution a winner is picked for each field: the address field is bits NSLOT..2*NSLOT-1 and the data field is bits 0..NSLOT-1. Slots whose urgent bit is also set are picked ahead of the others. The valid flags show from the address cycle on.
- R5: Inside a field, the pick goes round-robin. The search starts at the slot after that field's previous winner. After reset it starts at slot 0.
- R6: In the address cycle, the address winner (if it is this slot) enables addr_oe and drives req_addr and req_cmd. The data winner (if it is this slot) enables tag_oe and drives rsp_tag. Outside those cases, none of these three is enabled.
- R7: In the decode cycle the slot enables no line bit, no address, no command and no tag.
- R8: In acknowledge the slot enables only bit SLOT_ID and drives fb_present on it. ack_vec shows the lines seen in acknowledge from the next cycle on.
- R9: A data winner produces four beats, in acknowledge, arbitration, resolution and address, with beat_idx 0 to 3. If this slot is the data winner, data_oe is high and beat k carries blk_data bits k*DW to k*DW+DW-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| want_data | input | 1 | Request the data bus |
| want_addr | input | 1 | Request the address bus |
| want_urgent | input | 1 | Mark this slot's requests urgent |
| req_addr | input | AW | Address to drive when granted |
| req_cmd | input | CW | Command to drive when granted |
| rsp_tag | input | TAGW | Response tag to drive when granted the data bus |
| blk_data | input | 4*DW | Block to send, beat 0 in the low bits |
| fb_present | input | 1 | Block-present feedback for acknowledge |
| lines_in | input | 3*NSLOT | Shared request/feedback lines as seen |
| lines_out | output | 3*NSLOT | Values this slot drives onto the lines |
| lines_oe | output | 3*NSLOT | Per-bit drive enables for the lines |
| addr_out | output | AW | Address bus drive |
| cmd_out | output | CW | Command bus drive |
| addr_oe | output | 1 | Address and command drive enable |
| tag_out | output | TAGW | Response tag drive |
| tag_oe | output | 1 | Response tag drive enable |
| data_out | output | DW | Data beat drive |
| data_oe | output | 1 | Data drive enable |
| xfer_act | output | 1 | A data beat is on the bus this cycle |
| beat_idx | output | 2 | Index of the current beat |
| phase | output | 3 | Current phase code |
| awin_vld | output | 1 | An address winner exists |
| awin_id | output | log2(NSLOT) | Address winner slot |
| dwin_vld | output | 1 | A data winner exists |
| dwin_id | output | log2(NSLOT) | Data winner slot |
| ack_vec | output | 3*NSLOT | Feedback captured in acknowledge |

## Verification
The bench builds the block with four slots and sits at slot 2, with an 8-bit beat width and short address and command fields. With four slots, every rotation of the round-robin pointers and every mix of urgent and normal requests comes up often in a few thousand random cycles. The other slots' lines are random, with a quiet opening stretch that exercises the idle loop. A later stretch where only this slot requests makes sure it often wins both buses, so its own beats, tag and address drives are checked repeatedly.

// File: rtl/slot_bus_seq.sv
`timescale 1ns/1ps
module slot_bus_seq #(
  parameter int NSLOT   = 16,
  parameter int SLOT_ID = 0,
  parameter int AW      = 40,
  parameter int CW      = 8,
  parameter int TAGW    = 3,
  parameter int DW      = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     want_data,
  input  logic                     want_addr,
  input  logic                     want_urgent,
  input  logic [AW-1:0]            req_addr,
  input  logic [CW-1:0]            req_cmd,
  input  logic [TAGW-1:0]          rsp_tag,
  input  logic [4*DW-1:0]          blk_data,
  input  logic                     fb_present,
  input  logic [3*NSLOT-1:0]       lines_in,
  output logic [3*NSLOT-1:0]       lines_out,
  output logic [3*NSLOT-1:0]       lines_oe,
  output logic [AW-1:0]            addr_out,
  output logic [CW-1:0]            cmd_out,
  output logic                     addr_oe,
  output logic [TAGW-1:0]          tag_out,
  output logic                     tag_oe,
  output logic [DW-1:0]            data_out,
  output logic                     data_oe,
  output logic                     xfer_act,
  output logic [1:0]               beat_idx,
  output logic [2:0]               phase,
  output logic                     awin_vld,
  output logic [((NSLOT>1)?$clog2(NSLOT):1)-1:0] awin_id,
  output logic                     dwin_vld,
  output logic [((NSLOT>1)?$clog2(NSLOT):1)-1:0] dwin_id,
  output logic [3*NSLOT-1:0]       ack_vec
);
  localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int LW = 3 * NSLOT;
  localparam logic [IW-1:0] ME = IW'(SLOT_ID);
  localparam logic [LW-1:0] BIT_D = LW'(1) << SLOT_ID;
  localparam logic [LW-1:0] BIT_A = LW'(1) << (NSLOT + SLOT_ID);
  localparam logic [LW-1:0] BIT_U = LW'(1) << (2 * NSLOT + SLOT_ID);

  typedef enum logic [2:0] {
    PH_ARB = 3'd0, PH_RES = 3'd1, PH_ADR = 3'd2,
    PH_DEC = 3'd3, PH_ACK = 3'd4, PH_IDL = 3'd5
  } ph_t;

  ph_t st;
  logic [LW-1:0] snap;
  logic [IW-1:0] ptr_a, ptr_d;
  logic          mine;

  function automatic logic [IW:0] rr_pick(input logic [NSLOT-1:0] m, input logic [IW-1:0] last);
    logic [IW:0] r;
    r = '0;
    for (int i = NSLOT; i >= 1; i--) begin
      int k;
      k = (int'(last) + i) % NSLOT;
      if (m[k]) r = {1'b1, k[IW-1:0]};
    end
    return r;
  endfunction

  wire [NSLOT-1:0] f_dat = snap[NSLOT-1:0];
  wire [NSLOT-1:0] f_adr = snap[2*NSLOT-1:NSLOT];
  wire [NSLOT-1:0] f_urg = snap[3*NSLOT-1:2*NSLOT];
  wire [NSLOT-1:0] m_adr = (|(f_adr & f_urg)) ? (f_adr & f_urg) : f_adr;
  wire [NSLOT-1:0] m_dat = (|(f_dat & f_urg)) ? (f_dat & f_urg) : f_dat;
  wire [IW:0]      pk_a  = rr_pick(m_adr, ptr_a);
  wire [IW:0]      pk_d  = rr_pick(m_dat, ptr_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= PH_ARB;
      snap     <= '0;
      ptr_a    <= IW'(NSLOT - 1);
      ptr_d    <= IW'(NSLOT - 1);
      awin_vld <= 1'b0;
      awin_id  <= '0;
      dwin_vld <= 1'b0;
      dwin_id  <= '0;
      xfer_act <= 1'b0;
      beat_idx <= '0;
      mine     <= 1'b0;
      ack_vec  <= '0;
    end else begin
      if (xfer_act) begin
        if (beat_idx == 2'd3) xfer_act <= 1'b0;
        else beat_idx <= beat_idx + 2'd1;
      end
      case (st)
        PH_ARB: begin
          snap <= lines_in;
          st   <= (|lines_in || xfer_act) ? PH_RES : PH_IDL;
        end
        PH_RES: begin
          st       <= PH_ADR;
          awin_vld <= pk_a[IW];
          dwin_vld <= pk_d[IW];
          if (pk_a[IW]) begin awin_id <= pk_a[IW-1:0]; ptr_a <= pk_a[IW-1:0]; end
          if (pk_d[IW]) begin dwin_id <= pk_d[IW-1:0]; ptr_d <= pk_d[IW-1:0]; end
        end
        PH_ADR: st <= PH_DEC;
        PH_DEC: begin
          st <= PH_ACK;
          if (dwin_vld) begin
            xfer_act <= 1'b1;
            beat_idx <= '0;
            mine     <= (dwin_id == ME);
          end
        end
        PH_ACK: begin
          ack_vec <= lines_in;
          st      <= PH_ARB;
        end
        default: st <= PH_ARB;
      endcase
    end
  end

  assign phase     = st;
  assign lines_oe  = (st == PH_ARB) ? (BIT_D | BIT_A | BIT_U) :
                     (st == PH_ACK) ? BIT_D : '0;
  assign lines_out = (st == PH_ARB) ? (({LW{want_data}} & BIT_D) | ({LW{want_addr}} & BIT_A) |
                                       ({LW{want_urgent}} & BIT_U)) :
                     (st == PH_ACK) ? ({LW{fb_present}} & BIT_D) : '0;
  assign addr_oe   = (st == PH_ADR) && awin_vld && (awin_id == ME);
  assign addr_out  = addr_oe ? req_addr : '0;
  assign cmd_out   = addr_oe ? req_cmd : '0;
  assign tag_oe    = (st == PH_ADR) && dwin_vld && (dwin_id == ME);
  assign tag_out   = tag_oe ? rsp_tag : '0;
  assign data_oe   = xfer_act && mine;
  assign data_out  = data_oe ? blk_data[int'(beat_idx)*DW +: DW] : '0;

  assert_phase_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_RES) |=> (st == PH_ADR));
  assert_ack_wraps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_ACK) |=> (st == PH_ARB));
  assert_idle_return_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_IDL) |=> (st == PH_ARB));
  assert_urgent_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_ADR && awin_vld && |(f_adr & f_urg)) |-> f_urg[awin_id]);
  assert_addr_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_oe || tag_oe) |-> (st == PH_ADR));
  assert_dec_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_DEC) |-> (lines_oe == '0 && !addr_oe && !tag_oe));
  assert_beat_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_act) |-> (st == PH_ACK && beat_idx == 2'd0));
endmodule

// File: tb/slot_bus_seq_tb.sv
`timescale 1ns/1ps
module slot_bus_seq_tb;
  localparam int N = 4, ME = 2, AW = 8, CW = 4, TW = 3, DW = 8, LW = 3 * N, NCYC = 4000;

  logic clk = 0, rst_n = 0;
  logic want_data = 0, want_addr = 0, want_urgent = 0, fb_present = 0;
  logic [AW-1:0] req_addr = 0;
  logic [CW-1:0] req_cmd = 0;
  logic [TW-1:0] rsp_tag = 0;
  logic [4*DW-1:0] blk_data = 0;
  logic [LW-1:0] others = 0;
  logic [LW-1:0] lines_in, lines_out, lines_oe, ack_vec;
  logic [AW-1:0] addr_out;
  logic [CW-1:0] cmd_out;
  logic [TW-1:0] tag_out;
  logic [DW-1:0] data_out;
  logic addr_oe, tag_oe, data_oe, xfer_act, awin_vld, dwin_vld;
  logic [1:0] beat_idx, awin_id, dwin_id;
  logic [2:0] phase;

  always #2.5 clk = ~clk;
  assign lines_in = others | (lines_out & lines_oe);

  slot_bus_seq #(.NSLOT(N), .SLOT_ID(ME), .AW(AW), .CW(CW), .TAGW(TW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .want_data(want_data), .want_addr(want_addr),
    .want_urgent(want_urgent), .req_addr(req_addr), .req_cmd(req_cmd), .rsp_tag(rsp_tag),
    .blk_data(blk_data), .fb_present(fb_present), .lines_in(lines_in),
    .lines_out(lines_out), .lines_oe(lines_oe), .addr_out(addr_out), .cmd_out(cmd_out),
    .addr_oe(addr_oe), .tag_out(tag_out), .tag_oe(tag_oe), .data_out(data_out),
    .data_oe(data_oe), .xfer_act(xfer_act), .beat_idx(beat_idx), .phase(phase),
    .awin_vld(awin_vld), .awin_id(awin_id), .dwin_vld(dwin_vld), .dwin_id(dwin_id),
    .ack_vec(ack_vec));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string rq, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", rq, $time, act, exp);
    end
  endtask

  int m_ph, m_snap, m_pa, m_pd, m_av, m_aid, m_dv, m_did, m_xfer, m_beat, m_mine, m_ack;

  function automatic int pick_rr(int req, int urg, int last);
    int msk;
    msk = ((req & urg) != 0) ? (req & urg) : req;
    for (int i = 1; i <= N; i++)
      if ((msk >> ((last + i) % N)) & 1) return (last + i) % N;
    return -1;
  endfunction

  initial begin
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      rst_n = (c >= 3);
      if (c < 40) begin
        others = 0; want_data = 0; want_addr = 0; want_urgent = 0;
      end else if (c >= 1500 && c < 2000) begin
        others = 0;
        want_data = ($urandom % 2) == 0; want_addr = ($urandom % 2) == 0;
        want_urgent = ($urandom % 4) == 0;
      end else begin
        others = LW'($urandom & $urandom) & ~((LW'(1) << ME) | (LW'(1) << (N + ME)) | (LW'(1) << (2 * N + ME)));
        want_data = ($urandom % 3) == 0; want_addr = ($urandom % 3) == 0;
        want_urgent = ($urandom % 5) == 0;
      end
      fb_present = $urandom % 2;
      req_addr = AW'($urandom); req_cmd = CW'($urandom); rsp_tag = TW'($urandom);
      blk_data = $urandom;
      #1;
      if (c >= 1) begin
        int eoe, eout, amine, dmine;
        eoe = (m_ph == 0) ? ((1 << ME) | (1 << (N + ME)) | (1 << (2 * N + ME))) : (m_ph == 4) ? (1 << ME) : 0;
        eout = (m_ph == 0) ? ((int'(want_data) << ME) | (int'(want_addr) << (N + ME)) | (int'(want_urgent) << (2 * N + ME)))
             : (m_ph == 4) ? (int'(fb_present) << ME) : 0;
        amine = (m_ph == 2 && m_av && m_aid == ME);
        dmine = (m_ph == 2 && m_dv && m_did == ME);
        if (c == 3) chk("R1 reset phase", phase, 0);
        chk(m_ph == 5 ? "R2 idle phase" : "R1 phase", phase, m_ph);
        chk(m_ph == 3 ? "R7 decode enables" : m_ph == 4 ? "R8 ack enables" : "R3 line enables", lines_oe, eoe);
        chk(m_ph == 4 ? "R8 feedback drive" : "R3 request drive", lines_out & lines_oe, eout);
        chk("R8 ack_vec", ack_vec, m_ack);
        chk(m_ph == 3 ? "R7 addr_oe" : "R6 addr_oe", addr_oe, amine);
        chk(m_ph == 3 ? "R7 tag_oe" : "R6 tag_oe", tag_oe, dmine);
        if (amine) begin chk("R6 addr", addr_out, req_addr); chk("R6 cmd", cmd_out, req_cmd); end
        if (dmine) chk("R6 tag", tag_out, rsp_tag);
        if (m_ph == 2) begin
          chk("R4 addr winner valid", awin_vld, m_av);
          chk("R4 data winner valid", dwin_vld, m_dv);
          if (m_av) chk("R5 addr winner id", awin_id, m_aid);
          if (m_dv) chk("R5 data winner id", dwin_id, m_did);
        end
        chk("R9 xfer_act", xfer_act, m_xfer);
        chk("R9 data_oe", data_oe, m_xfer && m_mine);
        if (m_xfer) chk("R9 beat_idx", beat_idx, m_beat);
        if (m_xfer && m_mine) chk("R9 data beat", data_out, (blk_data >> (m_beat * DW)) & 8'hff);
      end
      if (!rst_n) begin
        m_ph = 0; m_snap = 0; m_pa = N - 1; m_pd = N - 1; m_av = 0; m_aid = 0;
        m_dv = 0; m_did = 0; m_xfer = 0; m_beat = 0; m_mine = 0; m_ack = 0;
      end else begin
        int li, ox, wa, wd;
        li = int'(lines_in);
        ox = m_xfer;
        if (m_xfer) begin
          if (m_beat == 3) m_xfer = 0; else m_beat++;
        end
        case (m_ph)
          0: begin m_snap = li; m_ph = (li != 0 || ox) ? 1 : 5; end
          1: begin
            wa = pick_rr((m_snap >> N) & 15, (m_snap >> (2 * N)) & 15, m_pa);
            wd = pick_rr(m_snap & 15, (m_snap >> (2 * N)) & 15, m_pd);
            m_av = (wa >= 0); m_dv = (wd >= 0);
            if (wa >= 0) begin m_aid = wa; m_pa = wa; end
            if (wd >= 0) begin m_did = wd; m_pd = wd; end
            m_ph = 2;
          end
          2: m_ph = 3;
          3: begin
            m_ph = 4;
            if (m_dv) begin m_xfer = 1; m_beat = 0; m_mine = (m_did == ME); end
          end
          4: begin m_ack = li; m_ph = 0; end
          default: m_ph = 0;
        endcase
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule